// File: doc/BRIEF.md
# Register-Bank Exchange Sorter

This block keeps a small bank of `K` unsigned `N`-bit registers and reorders them so that the smallest value sits at address 0 and the largest at address `K-1`. A host fills the bank one word at a time through an address and data port while the mode input is low. It then raises the mode input to start the sort, and waits for the completion flag. Finally it reads the ordered words back through the same address port.

The sort is a nested-loop exchange sort run by a finite-state controller over a single-ported register bank. An outer index `i` walks from 0 to `K-2`, and each pass first copies `R[i]` into a working register A. An inner index `j` walks from `i+1` to `K-1`. For each `j`, the block copies `R[j]` into a second working register B and compares it with A. If B is strictly smaller than A, the block writes B into `R[i]` and A into `R[j]`, then reloads A from `R[i]` before `j` moves on. Each controller state performs its register actions in a single clock cycle.

Top module: `xchg_sorter`

## Requirements
- R1: When `rstN` is low, the block clears every bank register to 0 and drops `done`. The clear is asynchronous.
- R2: While the controller is idle and `sortMode` is 0, a rising edge with `wrInit` high stores `dataIn` into the register addressed by `regAddr`.
- R3: `dataOut` shows the register addressed by `regAddr` when `rdEn` is high and the controller is either idle or finished. At all other times `dataOut` is 0, including any time `rdEn` is low and any time a sort is running.
- R4: When the idle controller samples `sortMode` high, a sort starts. The sort ends with the bank holding the original values in ascending order.
- R5: Equal values are never exchanged. Duplicate values still end up correctly ordered.
- R6: `done` rises only when a sort completes. It then stays high for as long as `sortMode` stays 1.
- R7: When the finished controller samples `sortMode` low, `done` falls at that edge and the block returns to idle.
- R8: `wrInit` has no effect on the bank while a sort is running or while `done` is high.
- R9: The comparison is unsigned, so a word with its top bit set sorts above every word that has its top bit clear.
- R10: With `K=4`, consider input that needs no exchange. Count edges from the edge where the idle controller samples `sortMode` high. `done` is high after the 15th rising edge after that one, and each exchange adds 3 more edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | N | Word to load |
| regAddr | input | L = $clog2(K) | Bank address for loading and reading |
| wrInit | input | 1 | Load strobe, used in idle with `sortMode` = 0 |
| sortMode | input | 1 | 0 = load or read, 1 = sort |
| rdEn | input | 1 | Read enable for `dataOut` |
| dataOut | output | N | Addressed word, or 0 when reading is not allowed |
| done | output | 1 | Sort finished, result ready |

## Verification
The assertions assume the host does not lower `sortMode` in the middle of a sort. They also assume `regAddr` only moves when the host intends a new read, so a stable address while `done` is high should give a stable `dataOut`. The directed stimulus keeps to these assumptions. It changes inputs only on falling edges and keeps `sortMode` high from the start of a sort until after `done` has been seen. Writes attempted during a sort are injected on purpose, because the block is required to ignore them.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

  typedef enum logic [1:0] {
    WSEL_IN = 2'd0,
    WSEL_A  = 2'd1,
    WSEL_B  = 2'd2
  } wsel_e;

  typedef enum logic [1:0] {
    ASEL_EXT = 2'd0,
    ASEL_I   = 2'd1,
    ASEL_J   = 2'd2
  } asel_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic  ldI;
    logic  enI;
    logic  ldJ;
    logic  enJ;
    logic  ldA;
    logic  ldB;
    logic  wrEn;
    wsel_e wrSel;
    asel_e addrSel;
    logic  readOk;
  } ctrl_t;

  // status from the datapath back to the controller
  typedef struct packed {
    logic bLtA;
    logic lastI;
    logic lastJ;
  } stat_t;

endpackage

// File: rtl/sorter_ctrl.sv
module sorter_ctrl
  import sorter_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  sortMode,
  input  logic  wrInit,
  input  stat_t stat,
  output ctrl_t ctrl,
  output logic  done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LDA, ST_LDB, ST_CMP, ST_WRI, ST_WRJ, ST_RELD, ST_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    ctrl.wrSel   = WSEL_IN;
    ctrl.addrSel = ASEL_EXT;
    nextState = state;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctrl.readOk = 1'b1;
        ctrl.ldI    = 1'b1;
        if (sortMode) nextState = ST_LDA;
        else          ctrl.wrEn = wrInit;
      end
      ST_LDA: begin
        ctrl.addrSel = ASEL_I;
        ctrl.ldA     = 1'b1;
        ctrl.ldJ     = 1'b1;
        nextState    = ST_LDB;
      end
      ST_LDB: begin
        ctrl.addrSel = ASEL_J;
        ctrl.ldB     = 1'b1;
        nextState    = ST_CMP;
      end
      ST_CMP: begin
        if (stat.bLtA) nextState = ST_WRI;
        else if (!stat.lastJ) begin
          ctrl.enJ  = 1'b1;
          nextState = ST_LDB;
        end else if (!stat.lastI) begin
          ctrl.enI  = 1'b1;
          nextState = ST_LDA;
        end else nextState = ST_DONE;
      end
      ST_WRI: begin
        ctrl.addrSel = ASEL_I;
        ctrl.wrSel   = WSEL_B;
        ctrl.wrEn    = 1'b1;
        nextState    = ST_WRJ;
      end
      ST_WRJ: begin
        ctrl.addrSel = ASEL_J;
        ctrl.wrSel   = WSEL_A;
        ctrl.wrEn    = 1'b1;
        nextState    = ST_RELD;
      end
      ST_RELD: begin
        ctrl.addrSel = ASEL_I;
        ctrl.ldA     = 1'b1;
        if (!stat.lastJ) begin
          ctrl.enJ  = 1'b1;
          nextState = ST_LDB;
        end else if (!stat.lastI) begin
          ctrl.enI  = 1'b1;
          nextState = ST_LDA;
        end else nextState = ST_DONE;
      end
      ST_DONE: begin
        done        = 1'b1;
        ctrl.readOk = 1'b1;
        if (!sortMode) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sorter_dp.sv
module sorter_dp
  import sorter_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4,
  localparam int L = (K > 1) ? $clog2(K) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] dataIn,
  input  logic [L-1:0] regAddr,
  input  logic         rdEn,
  input  ctrl_t        ctrl,
  output stat_t        stat,
  output logic [N-1:0] dataOut
);

  localparam logic [L-1:0] LAST_I = L'(K - 2);
  localparam logic [L-1:0] LAST_J = L'(K - 1);

  logic [N-1:0] bank [K];
  logic [N-1:0] aReg, bReg, wrData, rdData;
  logic [L-1:0] iIdx, jIdx, addr;

  always_comb begin
    unique case (ctrl.addrSel)
      ASEL_I:  addr = iIdx;
      ASEL_J:  addr = jIdx;
      default: addr = regAddr;
    endcase
  end

  always_comb begin
    unique case (ctrl.wrSel)
      WSEL_A:  wrData = aReg;
      WSEL_B:  wrData = bReg;
      default: wrData = dataIn;
    endcase
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < K; k++)
      if (addr == L'(k)) rdData = bank[k];
  end

  for (genvar g = 0; g < K; g++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            bank[g] <= '0;
      else if (ctrl.wrEn && addr == L'(g))  bank[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iIdx <= '0;
      jIdx <= '0;
      aReg <= '0;
      bReg <= '0;
    end else begin
      if (ctrl.ldI)      iIdx <= '0;
      else if (ctrl.enI) iIdx <= iIdx + 1'b1;
      if (ctrl.ldJ)      jIdx <= iIdx + 1'b1;
      else if (ctrl.enJ) jIdx <= jIdx + 1'b1;
      if (ctrl.ldA)      aReg <= rdData;
      if (ctrl.ldB)      bReg <= rdData;
    end
  end

  assign stat.bLtA  = bReg < aReg;
  assign stat.lastI = iIdx == LAST_I;
  assign stat.lastJ = jIdx == LAST_J;
  assign dataOut    = (rdEn && ctrl.readOk) ? rdData : '0;

endmodule

// File: rtl/xchg_sorter.sv
module xchg_sorter
  import sorter_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4,
  localparam int L = (K > 1) ? $clog2(K) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] dataIn,
  input  logic [L-1:0] regAddr,
  input  logic         wrInit,
  input  logic         sortMode,
  input  logic         rdEn,
  output logic [N-1:0] dataOut,
  output logic         done
);

  ctrl_t ctrl;
  stat_t stat;

  sorter_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sortMode(sortMode), .wrInit(wrInit),
    .stat(stat), .ctrl(ctrl), .done(done)
  );

  sorter_dp #(.N(N), .K(K)) dp_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .regAddr(regAddr),
    .rdEn(rdEn), .ctrl(ctrl), .stat(stat), .dataOut(dataOut)
  );

endmodule

// File: rtl/xchg_sorter_chk.sv
module xchg_sorter_chk #(
  parameter int N = 8,
  parameter int L = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic         sortMode,
  input logic         rdEn,
  input logic [L-1:0] regAddr,
  input logic [N-1:0] dataOut,
  input logic         done
);

  AST_OUT_LOW_NO_RD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> dataOut == '0); // R3

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done && sortMode |=> done); // R6

  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !done && !sortMode |=> !done); // R6

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    done && !sortMode |=> !done); // R7

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    done && $past(done) && rdEn && $past(rdEn) && $stable(regAddr)
    |-> $stable(dataOut)); // R8

endmodule

bind xchg_sorter xchg_sorter_chk #(.N(N), .L(L)) chk_i (
  .clk(clk), .rstN(rstN), .sortMode(sortMode), .rdEn(rdEn),
  .regAddr(regAddr), .dataOut(dataOut), .done(done)
);

// File: tb/xchg_sorter_tb_top.sv
`timescale 1ns/1ps
module xchg_sorter_tb_top;
  localparam int N = 8;
  localparam int K = 4;
  localparam int L = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] dataIn = '0;
  logic [L-1:0] regAddr = '0;
  logic         wrInit = 1'b0;
  logic         sortMode = 1'b0;
  logic         rdEn = 1'b0;
  logic [N-1:0] dataOut;
  logic         done;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xchg_sorter #(.N(N), .K(K)) dut_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .regAddr(regAddr),
    .wrInit(wrInit), .sortMode(sortMode), .rdEn(rdEn),
    .dataOut(dataOut), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  task automatic loadWords(input logic [N-1:0] v [K]);
    for (int a = 0; a < K; a++) begin
      @(negedge clk);
      regAddr = L'(a); dataIn = v[a]; wrInit = 1'b1;
    end
    @(negedge clk);
    wrInit = 1'b0;
  endtask

  task automatic readCheck(input logic [N-1:0] exp [K], input string req);
    @(negedge clk);
    rdEn = 1'b1;
    for (int a = 0; a < K; a++) begin
      regAddr = L'(a);
      #1;
      check(dataOut == exp[a], req, dataOut, exp[a]);
      @(negedge clk);
    end
    rdEn = 1'b0;
  endtask

  // ascending order model from the requirement, computed independently
  function automatic void sortModel(input logic [N-1:0] v [K], output logic [N-1:0] r [K]);
    r = v;
    for (int p = 1; p < K; p++)
      for (int q = p; q > 0 && r[q] < r[q-1]; q--) begin
        logic [N-1:0] t = r[q]; r[q] = r[q-1]; r[q-1] = t;
      end
  endfunction

  // starts a sort and returns edges until done (R10 counting)
  task automatic runSort(output int n, input bit poke);
    @(negedge clk);
    sortMode = 1'b1;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      if (poke && n == 3) begin
        regAddr = '0; dataIn = 8'hAA; wrInit = 1'b1;
      end
      if (done || n > 300) break;
      @(posedge clk);
      n++;
    end
    wrInit = 1'b0;
  endtask

  task automatic sortScenario(input logic [N-1:0] v [K], input int expCyc,
                              input string req, input bit poke);
    logic [N-1:0] exp [K];
    int n;
    loadWords(v);
    sortModel(v, exp);
    runSort(n, poke);
    check(done == 1'b1, "R6 done after sort", done, 1);
    if (expCyc > 0) check(n == expCyc, "R10 sort cycle count", n, expCyc);
    readCheck(exp, req);
    // R8: write attempt while done is ignored
    @(negedge clk);
    regAddr = '0; dataIn = 8'h55; wrInit = 1'b1;
    @(negedge clk);
    wrInit = 1'b0;
    check(done == 1'b1, "R6 done held", done, 1);
    readCheck(exp, "R8 write while done ignored");
    @(negedge clk);
    sortMode = 1'b0;
    @(posedge clk); #1;
    check(done == 1'b0, "R7 done clears", done, 0);
    readCheck(exp, "R3 read in idle after sort");
  endtask

  task automatic testReset();
    logic [N-1:0] z [K] = '{default: '0};
    @(negedge clk); #1;
    check(done == 1'b0, "R1 done low in reset", done, 0);
    @(negedge clk);
    rstN = 1'b1;
    readCheck(z, "R1 bank cleared");
  endtask

  task automatic testLoadRead();
    logic [N-1:0] v [K] = '{8'd9, 8'd17, 8'd3, 8'd250};
    loadWords(v);
    readCheck(v, "R2 load then read");
    @(negedge clk);
    rdEn = 1'b0; regAddr = 2'd3; #1;
    check(dataOut == '0, "R3 no rdEn gives zero", dataOut, 0);
  endtask

  task automatic testReadDuringSort();
    logic [N-1:0] v [K] = '{8'd40, 8'd30, 8'd20, 8'd10};
    loadWords(v);
    @(negedge clk);
    sortMode = 1'b1; rdEn = 1'b1; regAddr = 2'd1;
    @(posedge clk);
    @(negedge clk); #1;
    check(dataOut == '0, "R3 zero while sorting", dataOut, 0);
    check(done == 1'b0, "R6 no done mid sort", done, 0);
    rdEn = 1'b0;
    while (!done) @(negedge clk);
    sortMode = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    testReset();
    testLoadRead();
    sortScenario('{8'd4, 8'd3, 8'd2, 8'd1}, 33, "R4 reversed input sorted", 1'b0);
    sortScenario('{8'd1, 8'd2, 8'd3, 8'd4}, 15, "R4 sorted input kept", 1'b0);
    sortScenario('{8'd5, 8'd5, 8'd2, 8'd5}, 18, "R5 duplicates sorted", 1'b0);
    sortScenario('{8'h80, 8'h7F, 8'hFF, 8'h00}, 27, "R9 unsigned order", 1'b0);
    sortScenario('{8'd7, 8'd100, 8'd1, 8'd60}, 0, "R8 write during sort ignored", 1'b1);
    testReadDuringSort();
    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

endmodule